// File: doc/BRIEF.md
# Exception State Snapshot Recorder

This block keeps a snapshot of processor state taken at the moment of an exception, so that the state can be inspected later. Each pulse on the capture strobe samples five 32-bit values into a current record. These values are the trap value (the faulting address), the exception PC, the last data access address, the next PC and the current PC. Software handles the fault and then acknowledges it. If a second capture arrives before that acknowledge, the block treats it as a nested fault. It copies the trap value and the exception PC of the older record into a previous record, captures the new values as current in the same cycle, and sets a nested-fault flag.

The contents are read back one 32-bit word at a time through a registered read port. The word order is fixed: the five current fields, then the two previous-record fields, then a status word with the nested-fault flag in bit 0.

A small state machine controls the capture. The states are `CD_EMPTY` (nothing captured since reset), `CD_ARMED` (a fault has been captured and not yet acknowledged) and `CD_HANDLED` (the last fault has been acknowledged). The transitions are:
- EMPTY→ARMED on a capture (first capture).
- ARMED→ARMED on a capture (nested capture).
- ARMED→HANDLED on an acknowledge with no capture in the same cycle.
- HANDLED→ARMED on a capture (single capture).

Every other case holds the state.

Top module: `cdump_top`

## Requirements
- R1: While and after reset, every record word is zero, the nested-fault flag is 0, `armed_o` is 0, `rd_valid_o` is 0 and the state is `CD_EMPTY`.
- R2: A cycle with `fault_i` high stores the five inputs at that clock edge into the current record. They are read back at word index 0 (trap value), 1 (exception PC), 2 (data address), 3 (next PC) and 4 (current PC).
- R3: A capture made while not armed (from `CD_EMPTY` or `CD_HANDLED`) leaves the previous record and the nested-fault flag unchanged.
- R4: A capture made while armed does three things at the same clock edge. It copies the old current trap value and exception PC into the previous record, stores the new five values as current, and sets the nested-fault flag.
- R5: The nested-fault flag is sticky until reset. Word index 7 returns it in bit 0, and bits 31:1 of that word are zero.
- R6: `armed_o` goes high one cycle after any capture. An acknowledge while armed, with no capture in the same cycle, drops `armed_o` one cycle later. An acknowledge while not armed has no effect.
- R7: When a capture and an acknowledge arrive in the same cycle, the capture wins. It is handled as nested or single according to the state before the edge, and the block is armed afterwards.
- R8: A read request sampled at edge N presents the addressed word on `rd_data_o` with `rd_valid_o` high after edge N, using the contents from before that edge. In a cycle without a request, `rd_data_o` is zero after the edge.
- R9: Word index 5 returns the previous trap value and word index 6 returns the previous exception PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Capture strobe, one cycle per exception |
| ack_i | input | 1 | Software acknowledge of the armed fault |
| trap_val_i | input | 32 | Faulting address to capture |
| exc_pc_i | input | 32 | Exception PC to capture |
| data_addr_i | input | 32 | Last data access address to capture |
| next_pc_i | input | 32 | Next PC to capture |
| cur_pc_i | input | 32 | Current PC to capture |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 3 | Word index of the read |
| rd_data_o | output | 32 | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |
| armed_o | output | 1 | An unacknowledged fault is held |
| double_o | output | 1 | Nested-fault flag |

## Verification
The assertions assume that `fault_i`, `ack_i` and the read inputs change only away from the rising edge and are known after reset. They also assume that a capture strobe means exactly one exception per high cycle. The stimulus changes every input on the falling edge and holds each strobe for one cycle. It never issues a read in the same cycle as a capture, so each expected word comes from a quiet record. Same-cycle capture and acknowledge are driven on purpose, in both the armed and the handled state, because R7 defines that overlap.

// File: rtl/cdump_pkg.sv
package cdump_pkg;

    localparam int unsigned CUR_FIELDS  = 5;
    localparam int unsigned PREV_FIELDS = 2;
    localparam int unsigned DUMP_WORDS  = CUR_FIELDS + PREV_FIELDS + 1;
    localparam int unsigned STATUS_IDX  = CUR_FIELDS + PREV_FIELDS;

    // Field order inside the current record; previous record reuses the first two.
    localparam int unsigned FLD_TRAP  = 0;
    localparam int unsigned FLD_EPC   = 1;
    localparam int unsigned FLD_DADDR = 2;
    localparam int unsigned FLD_NPC   = 3;
    localparam int unsigned FLD_CPC   = 4;

    typedef enum logic [1:0] {
        CD_EMPTY   = 2'd0,
        CD_ARMED   = 2'd1,
        CD_HANDLED = 2'd2
    } cd_state_e;

    typedef enum logic [1:0] {
        CAP_NONE   = 2'd0,
        CAP_SINGLE = 2'd1,
        CAP_DOUBLE = 2'd2
    } cap_kind_e;

endpackage

// File: rtl/cdump_fsm.sv
module cdump_fsm
    import cdump_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      fault_i,
    input  logic      ack_i,
    output cap_kind_e cap_kind_o,
    output logic      armed_o,
    output logic      double_o
);

    cd_state_e state_q, state_d;
    logic      double_q;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: capture has priority over acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_EMPTY: begin
                if (fault_i) state_d = CD_ARMED;
            end
            CD_ARMED: begin
                if (fault_i)    state_d = CD_ARMED;
                else if (ack_i) state_d = CD_HANDLED;
            end
            CD_HANDLED: begin
                if (fault_i) state_d = CD_ARMED;
            end
            default: state_d = CD_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        cap_kind_o = CAP_NONE;
        armed_o    = 1'b0;
        unique case (state_q)
            CD_EMPTY: begin
                if (fault_i) cap_kind_o = CAP_SINGLE;
            end
            CD_ARMED: begin
                armed_o = 1'b1;
                if (fault_i) cap_kind_o = CAP_DOUBLE;
            end
            CD_HANDLED: begin
                if (fault_i) cap_kind_o = CAP_SINGLE;
            end
            default: cap_kind_o = CAP_NONE;
        endcase
    end

    // Sticky nested-fault flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            double_q <= 1'b0;
        end else if (cap_kind_o == CAP_DOUBLE) begin
            double_q <= 1'b1;
        end
    end

    assign double_o = double_q;

    a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        double_q |=> double_q);

    a_r4_nested_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CD_ARMED && fault_i) |=> double_q);

    a_r7_capture_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |=> (state_q == CD_ARMED));

    a_r6_ack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CD_ARMED && ack_i && !fault_i) |=> (state_q == CD_HANDLED));

    a_r6_ack_idle_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != CD_ARMED && !fault_i) |=> $stable(state_q));

endmodule

// File: rtl/cdump_store.sv
module cdump_store
    import cdump_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  cap_kind_e                             cap_kind_i,
    input  logic [CUR_FIELDS-1:0][XLEN-1:0]       fields_i,
    output logic [CUR_FIELDS-1:0][XLEN-1:0]       cur_o,
    output logic [PREV_FIELDS-1:0][XLEN-1:0]      prev_o
);

    logic [CUR_FIELDS-1:0][XLEN-1:0]  cur_q;
    logic [PREV_FIELDS-1:0][XLEN-1:0] prev_q;

    for (genvar gi = 0; gi < CUR_FIELDS; gi++) begin : g_cur
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                cur_q[gi] <= '0;
            end else if (cap_kind_i != CAP_NONE) begin
                cur_q[gi] <= fields_i[gi];
            end
        end
    end

    // Only the leading fields survive into the previous record
    for (genvar gj = 0; gj < PREV_FIELDS; gj++) begin : g_prev
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                prev_q[gj] <= '0;
            end else if (cap_kind_i == CAP_DOUBLE) begin
                prev_q[gj] <= cur_q[gj];
            end
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

    a_r3_prev_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_kind_i != CAP_DOUBLE) |=> $stable(prev_q));

    a_r2_cur_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_kind_i == CAP_NONE) |=> $stable(cur_q));

endmodule

// File: rtl/cdump_reader.sv
module cdump_reader
    import cdump_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IDX_W = 3
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              rd_en_i,
    input  logic [IDX_W-1:0]                  rd_idx_i,
    input  logic [CUR_FIELDS-1:0][XLEN-1:0]   cur_i,
    input  logic [PREV_FIELDS-1:0][XLEN-1:0]  prev_i,
    input  logic                              double_i,
    output logic [XLEN-1:0]                   rd_data_o,
    output logic                              rd_valid_o
);

    logic [XLEN-1:0] word_sel;

    always_comb begin
        word_sel = '0;
        for (int k = 0; k < CUR_FIELDS; k++) begin
            if (32'(rd_idx_i) == k) word_sel = cur_i[k];
        end
        for (int k = 0; k < PREV_FIELDS; k++) begin
            if (32'(rd_idx_i) == CUR_FIELDS + k) word_sel = prev_i[k];
        end
        if (32'(rd_idx_i) == STATUS_IDX) word_sel = {{(XLEN-1){1'b0}}, double_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
            rd_data_o  <= rd_en_i ? word_sel : '0;
        end
    end

    a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_valid_o);

    a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rd_data_o == '0 && !rd_valid_o));

    a_r5_status_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && 32'(rd_idx_i) == STATUS_IDX) |=> (rd_data_o[XLEN-1:1] == '0));

endmodule

// File: rtl/cdump_top.sv
module cdump_top
    import cdump_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    localparam int unsigned IDX_W = $clog2(DUMP_WORDS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fault_i,
    input  logic              ack_i,
    input  logic [XLEN-1:0]   trap_val_i,
    input  logic [XLEN-1:0]   exc_pc_i,
    input  logic [XLEN-1:0]   data_addr_i,
    input  logic [XLEN-1:0]   next_pc_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [XLEN-1:0]   rd_data_o,
    output logic              rd_valid_o,
    output logic              armed_o,
    output logic              double_o
);

    cap_kind_e                          cap_kind;
    logic [CUR_FIELDS-1:0][XLEN-1:0]    fields;
    logic [CUR_FIELDS-1:0][XLEN-1:0]    cur_rec;
    logic [PREV_FIELDS-1:0][XLEN-1:0]   prev_rec;

    always_comb begin
        fields            = '0;
        fields[FLD_TRAP]  = trap_val_i;
        fields[FLD_EPC]   = exc_pc_i;
        fields[FLD_DADDR] = data_addr_i;
        fields[FLD_NPC]   = next_pc_i;
        fields[FLD_CPC]   = cur_pc_i;
    end

    cdump_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fault_i    (fault_i),
        .ack_i      (ack_i),
        .cap_kind_o (cap_kind),
        .armed_o    (armed_o),
        .double_o   (double_o)
    );

    cdump_store #(.XLEN(XLEN)) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_kind_i (cap_kind),
        .fields_i   (fields),
        .cur_o      (cur_rec),
        .prev_o     (prev_rec)
    );

    cdump_reader #(.XLEN(XLEN), .IDX_W(IDX_W)) u_reader (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_en_i    (rd_en_i),
        .rd_idx_i   (rd_idx_i),
        .cur_i      (cur_rec),
        .prev_i     (prev_rec),
        .double_i   (double_o),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    a_r2_trap_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |=> (cur_rec[FLD_TRAP] == $past(trap_val_i)
                     && cur_rec[FLD_CPC] == $past(cur_pc_i)));

    a_r4_nested_moves_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_i && armed_o) |=> (prev_rec[FLD_TRAP] == $past(cur_rec[FLD_TRAP])
                                  && prev_rec[FLD_EPC] == $past(cur_rec[FLD_EPC])));

    a_r6_armed_after_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |=> armed_o);

    a_r3_flag_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!armed_o && !double_o) |=> !double_o);

endmodule

// File: tb/cdump_top_tb_top.sv
module cdump_top_tb_top;

    localparam int XLEN = 32;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            fault_i = 1'b0;
    logic            ack_i = 1'b0;
    logic [XLEN-1:0] trap_val_i = '0, exc_pc_i = '0, data_addr_i = '0,
                     next_pc_i = '0, cur_pc_i = '0;
    logic            rd_en_i = 1'b0;
    logic [2:0]      rd_idx_i = '0;
    logic [XLEN-1:0] rd_data_o;
    logic            rd_valid_o, armed_o, double_o;

    always #5 clk_i = ~clk_i;

    cdump_top dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .ack_i(ack_i),
        .trap_val_i(trap_val_i), .exc_pc_i(exc_pc_i), .data_addr_i(data_addr_i),
        .next_pc_i(next_pc_i), .cur_pc_i(cur_pc_i),
        .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
        .armed_o(armed_o), .double_o(double_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model built from the requirements
    logic [XLEN-1:0] m_cur [5];
    logic [XLEN-1:0] m_prev [2];
    logic            m_dbl, m_armed;

    // Scoreboard queues
    logic [XLEN-1:0] exp_q [$];
    string           tag_q [$];

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_word(input int k);
        if (k < 5)       return m_cur[k];
        else if (k < 7)  return m_prev[k-5];
        else             return {{(XLEN-1){1'b0}}, m_dbl};
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 5; k++) m_cur[k] = '0;
        for (int k = 0; k < 2; k++) m_prev[k] = '0;
        m_dbl = 1'b0;
        m_armed = 1'b0;
    endtask

    // Monitor: pops expected words as read data appears
    always @(negedge clk_i) begin
        if (rst_ni && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected read data actual=%h expected=none", rd_data_o);
            end else begin
                automatic logic [XLEN-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rd_data_o, e);
            end
        end
    end

    // Driver: issue back-to-back reads of every word
    task automatic read_all(input string tag);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk_i);
            rd_en_i  = 1'b1;
            rd_idx_i = 3'(k);
            exp_q.push_back(exp_word(k));
            tag_q.push_back($sformatf("%s word%0d", tag, k));
        end
        @(negedge clk_i);
        rd_en_i = 1'b0;
        @(negedge clk_i);
        check({tag, " R8 idle data zero"}, rd_data_o, '0);
    endtask

    task automatic fault(input logic [XLEN-1:0] base, input logic with_ack);
        @(negedge clk_i);
        fault_i     = 1'b1;
        ack_i       = with_ack;
        trap_val_i  = base;
        exc_pc_i    = base + 32'h111;
        data_addr_i = base + 32'h222;
        next_pc_i   = base + 32'h333;
        cur_pc_i    = base + 32'h444;
        if (m_armed) begin
            m_prev[0] = m_cur[0];
            m_prev[1] = m_cur[1];
            m_dbl     = 1'b1;
        end
        for (int k = 0; k < 5; k++) m_cur[k] = base + 32'(k) * 32'h111;
        m_armed = 1'b1;
        @(negedge clk_i);
        fault_i = 1'b0;
        ack_i   = 1'b0;
        trap_val_i = '0; exc_pc_i = '0; data_addr_i = '0; next_pc_i = '0; cur_pc_i = '0;
    endtask

    task automatic acknowledge();
        @(negedge clk_i);
        ack_i = 1'b1;
        m_armed = 1'b0;
        @(negedge clk_i);
        ack_i = 1'b0;
    endtask

    task automatic check_flags(input string tag);
        check({tag, " armed"}, XLEN'(armed_o), XLEN'(m_armed));
        check({tag, " double"}, XLEN'(double_o), XLEN'(m_dbl));
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk_i);
        check("R1 valid in reset", XLEN'(rd_valid_o), '0);
        check("R1 data in reset", rd_data_o, '0);
        check_flags("R1 reset");
        rst_ni = 1'b1;
        read_all("R1 R5 reset contents");

        // Acknowledge with nothing armed has no effect
        acknowledge();
        check_flags("R6 idle ack");
        read_all("R6 idle ack contents");

        // First fault
        fault(32'h1000_0000, 1'b0);
        check_flags("R2 R3 first fault");
        read_all("R2 R3 R9 single capture");

        // Nested fault
        fault(32'h2000_0000, 1'b0);
        check_flags("R4 nested fault");
        read_all("R4 R5 R9 nested capture");

        // Acknowledge, then acknowledge again while handled
        acknowledge();
        check_flags("R6 ack armed");
        acknowledge();
        check_flags("R6 ack handled");

        // Single capture after handling; previous record and flag persist
        fault(32'h3000_0000, 1'b0);
        check_flags("R3 R5 capture after ack");
        read_all("R3 R5 capture after ack");

        // Capture and ack together while armed: nested
        fault(32'h4000_0000, 1'b1);
        check_flags("R7 fault+ack armed");
        read_all("R7 R4 fault+ack armed");

        // Capture and ack together while handled: single
        acknowledge();
        fault(32'h5000_0000, 1'b1);
        check_flags("R7 fault+ack handled");
        read_all("R7 R3 fault+ack handled");

        // Reset clears everything again
        @(negedge clk_i);
        rst_ni = 1'b0;
        model_reset();
        @(negedge clk_i);
        check_flags("R1 second reset");
        rst_ni = 1'b1;
        read_all("R1 second reset contents");

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 reads missing actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule